// File: doc/BRIEF.md
# Watchdog Reset Timer

This block is a down-counting watchdog that drives two reset requests: a keyboard-controller reset and a power-good deassert. Software programs it through three byte-wide registers that arrive as single-cycle write strobes with an address and a data byte. One register holds the low byte of the timeout and one holds the high byte. The third is a control byte. It selects whether the count unit is seconds or minutes, and it enables each reset output on its own.

A prescaled `sec_tick` input supplies the seconds time base. The minutes base is built inside the block by counting `TICKS_PER_MIN` seconds ticks. Writing the low timeout byte loads the counter from the full value and restarts the minutes prescaler, so software kicks the watchdog by rewriting that byte. When the counter steps from one to zero, every enabled reset output is driven high for `PULSE_LEN` clock cycles. The counter then rests at zero until it is reloaded. A reduced-width build (`CNT_W = 8`) has no high byte and always counts in minutes.

Top module: `wdog_rst_timer`

## Requirements
- R1: After reset both reset outputs are low, the counter is zero, and seconds ticks alone never produce a pulse.
- R2: Register select `wr_addr` 0 is the timeout low byte, 1 is the timeout high byte and 2 is control. A write to address 0 loads the counter with {high byte, written byte} and restarts the minutes prescaler. Control bits 7..3 have no effect.
- R3: With control bit 0 set, the counter decrements on every `sec_tick`. With bit 0 clear, it decrements on every `TICKS_PER_MIN`-th `sec_tick` counted from the last low-byte write (default 60).
- R4: When the counter steps from 1 to 0, each output whose enable is set drives high from the next cycle for exactly `PULSE_LEN` cycles (default 16). Control bit 1 enables `kbd_rst` and bit 2 enables `pgood_rst`. An output whose enable is clear stays low.
- R5: After expiry the counter holds at zero, and no further pulse occurs until the low byte is written again.
- R6: Loading a timeout of zero leaves the timer disarmed: no pulse, whatever ticks follow.
- R7: Writing 0x00 to control clears the counter. Re-enabling control afterwards produces no pulse until the low byte is written again. A pulse already in progress runs to its full length.
- R8: A low-byte write in the same cycle as `sec_tick` takes priority: that tick is not counted.
- R9: With `CNT_W = 8`, writes to the high byte have no effect and the unit is always minutes, whatever control bit 0 holds.
- R10: Rewriting the low byte before expiry restarts the countdown from the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per second of time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| wr_data | input | 8 | Write data byte |
| kbd_rst | output | 1 | Keyboard reset request, high for PULSE_LEN cycles on expiry |
| pgood_rst | output | 1 | Power-good deassert request, high for PULSE_LEN cycles on expiry |

## Verification
The bench attacks the priority corners. A tick that lands in the same cycle as a reload would let the design fire one unit early. A zero control write that only masks the outputs would let a later re-enable fire a pulse from the stale count. It also checks that a kick resets the minutes prescaler phase, which catches a free-running prescaler because that design expires up to 59 seconds early. A second, narrow instance with a three-tick minute shows whether the high byte or the seconds bit leaks into the reduced build: either leak moves its expiry by hundreds of ticks or to two ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int NUM_OUTS = 2;

    // output lane indices
    localparam int OUT_KBD   = 0;
    localparam int OUT_PGOOD = 1;

    // control byte bit positions
    localparam int CTL_UNIT_SEC_BIT = 0;
    localparam int CTL_KBD_BIT      = 1;
    localparam int CTL_PGOOD_BIT    = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_TMO_LO = 2'd0,
        SEL_TMO_HI = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_OUTS-1:0] out_en;
        logic                unit_sec;
    } ctrl_t;

    typedef struct packed {
        logic lo;
        logic hi;
        logic ctl;
    } wr_hit_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_STEP  = 2'd3
    } cnt_act_e;

    function automatic wr_hit_t decode_sel(input logic en, input logic [ADDR_W-1:0] addr);
        wr_hit_t h;
        h.lo  = en && (reg_sel_e'(addr) == SEL_TMO_LO);
        h.hi  = en && (reg_sel_e'(addr) == SEL_TMO_HI);
        h.ctl = en && (reg_sel_e'(addr) == SEL_CTRL);
        return h;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [BYTE_W-1:0] d, input logic allow_sec);
        ctrl_t c;
        c.unit_sec          = d[CTL_UNIT_SEC_BIT] & allow_sec;
        c.out_en[OUT_KBD]   = d[CTL_KBD_BIT];
        c.out_en[OUT_PGOOD] = d[CTL_PGOOD_BIT];
        return c;
    endfunction

    // clear beats load beats step; stepping needs a nonzero count
    function automatic cnt_act_e pick_act(input logic clr, input logic ld,
                                          input logic step, input logic nonzero);
        if (clr)
            return ACT_CLEAR;
        else if (ld)
            return ACT_LOAD;
        else if (step && nonzero)
            return ACT_STEP;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              disarm,
    output ctrl_t             ctrl
);

    localparam bit WIDE = (CNT_W > BYTE_W);

    wr_hit_t hit;
    ctrl_t   ctrl_q;

    assign hit = decode_sel(wr_en, wr_addr);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (hit.ctl)
            ctrl_q <= unpack_ctrl(wr_data, WIDE);
    end

    assign ctrl   = ctrl_q;
    assign load   = hit.lo;
    assign disarm = hit.ctl && (wr_data == '0);

    generate
        if (WIDE) begin : g_wide
            localparam int HI_W = CNT_W - BYTE_W;
            logic [HI_W-1:0] hi_q;

            always_ff @(posedge clk) begin
                if (rst)
                    hi_q <= '0;
                else if (hit.hi)
                    hi_q <= wr_data[HI_W-1:0];
            end

            assign load_val = {hi_q, wr_data};
        end else begin : g_narrow
            assign load_val = wr_data[CNT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int TICKS_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    input  logic restart,
    input  logic unit_sec,
    output logic unit_tick
);

    localparam int PRE_W = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MIN - 1);
    localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

    logic [PRE_W-1:0] pre_q;
    logic             wrap;

    assign wrap = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            pre_q <= '0;
        else if (sec_tick)
            pre_q <= wrap ? '0 : pre_q + PRE_ONE;
    end

    assign unit_tick = sec_tick && !restart && (unit_sec || wrap);

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             disarm,
    input  logic             unit_tick,
    output logic             expire,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    cnt_act_e         act;

    assign act    = pick_act(disarm, load, unit_tick, cnt_q != '0);
    assign expire = (act == ACT_STEP) && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (act)
                ACT_CLEAR: cnt_q <= '0;
                ACT_LOAD:  cnt_q <= load_val;
                ACT_STEP:  cnt_q <= cnt_q - ONE;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int PULSE_LEN = 16,
    parameter int N_OUT     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [N_OUT-1:0] en,
    output logic [N_OUT-1:0] pulse
);

    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LEN    = PW'(PULSE_LEN);
    localparam logic [PW-1:0] ONE_PW = PW'(1);

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_lane
            logic [PW-1:0] left_q;

            always_ff @(posedge clk) begin
                if (rst)
                    left_q <= '0;
                else if (fire && en[i])
                    left_q <= LEN;
                else if (left_q != '0)
                    left_q <= left_q - ONE_PW;
            end

            assign pulse[i] = (left_q != '0);
        end
    endgenerate

endmodule

// File: rtl/wdog_rst_timer.sv
module wdog_rst_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int TICKS_PER_MIN = 60,
    parameter int PULSE_LEN     = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       kbd_rst,
    output logic       pgood_rst
);

    logic                load;
    logic [CNT_W-1:0]    load_val;
    logic                disarm;
    ctrl_t               ctrl;
    logic                unit_tick;
    logic                expire;
    logic [CNT_W-1:0]    count;
    logic [NUM_OUTS-1:0] pulse;

    wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load     (load),
        .load_val (load_val),
        .disarm   (disarm),
        .ctrl     (ctrl)
    );

    wdog_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .restart   (load),
        .unit_sec  (ctrl.unit_sec),
        .unit_tick (unit_tick)
    );

    wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (load_val),
        .disarm    (disarm),
        .unit_tick (unit_tick),
        .expire    (expire),
        .count     (count)
    );

    wdog_pulse #(.PULSE_LEN(PULSE_LEN), .N_OUT(NUM_OUTS)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (expire),
        .en    (ctrl.out_en),
        .pulse (pulse)
    );

    assign kbd_rst   = pulse[OUT_KBD];
    assign pgood_rst = pulse[OUT_PGOOD];

endmodule

// File: rtl/wdog_rst_timer_chk.sv
module wdog_rst_timer_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic             disarm,
    input logic             expire,
    input logic [CNT_W-1:0] count,
    input ctrl_t            ctrl,
    input logic             kbd_rst,
    input logic             pgood_rst
);

    localparam int RW = $clog2(PULSE_LEN + 2);
    localparam logic [RW-1:0] RMAX = RW'(PULSE_LEN + 1);
    localparam logic [RW-1:0] RLEN = RW'(PULSE_LEN);

    logic [RW-1:0] run_k;
    logic [RW-1:0] run_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_k <= '0;
            run_p <= '0;
        end else begin
            run_k <= kbd_rst   ? ((run_k == RMAX) ? RMAX : run_k + RW'(1)) : '0;
            run_p <= pgood_rst ? ((run_p == RMAX) ? RMAX : run_p + RW'(1)) : '0;
        end
    end

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));

    // R7
    disarm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        disarm |=> (count == '0));

    // R5
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((count == '0) && !load) |=> (count == '0));

    // R3
    no_climb_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> (count <= $past(count)));

    // R4
    kbd_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(kbd_rst) |-> $past(expire && ctrl.out_en[OUT_KBD]));

    // R4
    pgood_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pgood_rst) |-> $past(expire && ctrl.out_en[OUT_PGOOD]));

    // R4
    kbd_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(kbd_rst) |-> (run_k >= RLEN));

    // R4
    pgood_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pgood_rst) |-> (run_p >= RLEN));

endmodule

bind wdog_rst_timer wdog_rst_timer_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_val  (load_val),
    .disarm    (disarm),
    .expire    (expire),
    .count     (count),
    .ctrl      (ctrl),
    .kbd_rst   (kbd_rst),
    .pgood_rst (pgood_rst)
);

// File: tb/sim_wdog_rst_timer.sv
`timescale 1ns/100ps
module sim_wdog_rst_timer;

    localparam int TPM0 = 60;
    localparam int TPM1 = 3;
    localparam int PLEN = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] kbd;
    logic [1:0] pg;

    always #2.5 clk = ~clk;

    wdog_rst_timer #(.CNT_W(16), .TICKS_PER_MIN(TPM0), .PULSE_LEN(PLEN)) u0 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .kbd_rst(kbd[0]), .pgood_rst(pg[0]));

    wdog_rst_timer #(.CNT_W(8), .TICKS_PER_MIN(TPM1), .PULSE_LEN(PLEN)) u1 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .kbd_rst(kbd[1]), .pgood_rst(pg[1]));

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural reference, one slot per instance
    int m_cnt[2], m_hi[2], m_pre[2], m_kl[2], m_pl[2];
    bit m_sec[2], m_ke[2], m_pe[2];
    int hk[2], hp[2];

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            int tpm;
            bit lo_w, hi_w, ct_w, dis, ut, ex;
            tpm = (k == 0) ? TPM0 : TPM1;
            if (rst) begin
                m_cnt[k] = 0; m_hi[k] = 0; m_pre[k] = 0; m_kl[k] = 0; m_pl[k] = 0;
                m_sec[k] = 0; m_ke[k] = 0; m_pe[k] = 0;
            end else begin
                lo_w = wr_en && (wr_addr == 2'd0);
                hi_w = wr_en && (wr_addr == 2'd1);
                ct_w = wr_en && (wr_addr == 2'd2);
                dis  = ct_w && (wr_data == 8'h00);
                ut   = sec_tick && !lo_w && (m_sec[k] || (m_pre[k] == tpm - 1));
                ex   = ut && !dis && (m_cnt[k] == 1);
                if (ex && m_ke[k]) m_kl[k] = PLEN; else if (m_kl[k] > 0) m_kl[k]--;
                if (ex && m_pe[k]) m_pl[k] = PLEN; else if (m_pl[k] > 0) m_pl[k]--;
                if (lo_w) m_pre[k] = 0;
                else if (sec_tick) m_pre[k] = (m_pre[k] == tpm - 1) ? 0 : m_pre[k] + 1;
                if (dis) m_cnt[k] = 0;
                else if (lo_w) m_cnt[k] = ((k == 0) ? m_hi[k] * 256 : 0) + int'(wr_data);
                else if (ut && m_cnt[k] > 0) m_cnt[k]--;
                if (hi_w && k == 0) m_hi[k] = int'(wr_data);
                if (ct_w) begin
                    m_sec[k] = (k == 0) && wr_data[0];
                    m_ke[k]  = wr_data[1];
                    m_pe[k]  = wr_data[2];
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 2; k++) begin
                n_vec++;
                if (kbd[k] !== (m_kl[k] > 0)) begin
                    n_bad++;
                    $display("FAIL %s u%0d kbd_rst act=%b exp=%b at %0t", cur_req, k, kbd[k], m_kl[k] > 0, $time);
                end
                n_vec++;
                if (pg[k] !== (m_pl[k] > 0)) begin
                    n_bad++;
                    $display("FAIL %s u%0d pgood_rst act=%b exp=%b at %0t", cur_req, k, pg[k], m_pl[k] > 0, $time);
                end
                hk[k] += int'(kbd[k]);
                hp[k] += int'(pg[k]);
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input bit t);
        @(negedge clk); #1;
        wr_en = 1'b0; sec_tick = t;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit t = 1'b0);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d; sec_tick = t;
    endtask

    task automatic ticks(input int n);
        repeat (n) cyc(1'b1);
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b0);
    endtask

    task automatic clr_mon;
        hk[0] = 0; hk[1] = 0; hp[0] = 0; hp[1] = 0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        clr_mon();
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        idle(2);
        // R1: reset state and no pulse from ticks alone
        cur_req = "R1";
        chk("R1", "kbd_rst after reset", int'(kbd[0]), 0);
        chk("R1", "pgood_rst after reset", int'(pg[0]), 0);
        clr_mon();
        ticks(150); idle(2);
        chk("R1", "u0 kbd highs with no program", hk[0], 0);
        chk("R1", "u1 kbd highs with no program", hk[1], 0);

        // R4: seconds unit, keyboard lane only
        cur_req = "R4";
        wr(2'd2, 8'h03); wr(2'd1, 8'h00);
        clr_mon();
        wr(2'd0, 8'd5); ticks(5); idle(20);
        chk("R4", "u0 kbd pulse length", hk[0], PLEN);
        chk("R4", "u0 pgood stays low", hp[0], 0);

        // R5: stays expired
        cur_req = "R5";
        clr_mon(); ticks(60); idle(2);
        chk("R5", "u0 kbd after expiry", hk[0], 0);

        // R4: power-good lane only, then both
        cur_req = "R4";
        wr(2'd2, 8'h05); clr_mon();
        wr(2'd0, 8'd3); ticks(3); idle(20);
        chk("R4", "u0 pgood pulse length", hp[0], PLEN);
        chk("R4", "u0 kbd disabled", hk[0], 0);
        wr(2'd2, 8'h07); clr_mon();
        wr(2'd0, 8'd2); ticks(2); idle(20);
        chk("R4", "u0 kbd both enabled", hk[0], PLEN);
        chk("R4", "u0 pgood both enabled", hp[0], PLEN);

        // R3: minutes unit; upper control bits ignored (R2)
        cur_req = "R3";
        wr(2'd2, 8'hFA); clr_mon();
        wr(2'd0, 8'd2); ticks(119); idle(2);
        chk("R3", "u0 no pulse before 2 minutes", hk[0], 0);
        ticks(1); idle(20);
        chk("R3", "u0 pulse at 2 minutes", hk[0], PLEN);
        chk("R2", "u0 pgood ignores upper bits", hp[0], 0);

        // R2: high byte forms the upper half
        cur_req = "R2";
        wr(2'd2, 8'h03); wr(2'd1, 8'h01); clr_mon();
        wr(2'd0, 8'h00); ticks(255); idle(2);
        chk("R2", "u0 no pulse before 256 s", hk[0], 0);
        ticks(1); idle(20);
        chk("R2", "u0 pulse at 256 s", hk[0], PLEN);
        wr(2'd1, 8'h00);

        // R2: low-byte write restarts minutes prescaler
        wr(2'd2, 8'h02); wr(2'd0, 8'd1); ticks(40);
        clr_mon();
        wr(2'd0, 8'd1); ticks(59); idle(2);
        chk("R2", "u0 prescaler restarted by kick", hk[0], 0);
        ticks(1); idle(20);
        chk("R2", "u0 pulse one minute after kick", hk[0], PLEN);

        // R6: zero timeout
        cur_req = "R6";
        wr(2'd2, 8'h07); clr_mon();
        wr(2'd0, 8'd0); ticks(80); idle(2);
        chk("R6", "u0 kbd with zero timeout", hk[0], 0);
        chk("R6", "u0 pgood with zero timeout", hp[0], 0);
        chk("R6", "u1 kbd with zero timeout", hk[1], 0);

        // R7: control cleared disarms
        cur_req = "R7";
        wr(2'd2, 8'h03); wr(2'd0, 8'd10); ticks(5);
        wr(2'd2, 8'h00); wr(2'd2, 8'h03); clr_mon();
        ticks(30); idle(5);
        chk("R7", "u0 no pulse after disarm", hk[0], 0);
        chk("R7", "u1 no pulse after disarm", hk[1], 0);
        clr_mon();
        wr(2'd0, 8'd2); ticks(2); idle(3);
        wr(2'd2, 8'h00); idle(20);
        chk("R7", "u0 pulse completes after clear", hk[0], PLEN);

        // R8: load wins over simultaneous tick
        cur_req = "R8";
        wr(2'd2, 8'h03); clr_mon();
        wr(2'd0, 8'd3, 1'b1); ticks(2); idle(3);
        chk("R8", "u0 tick at load not counted", hk[0], 0);
        ticks(1); idle(20);
        chk("R8", "u0 pulse after three more ticks", hk[0], PLEN);

        // R10: kick restarts countdown
        cur_req = "R10";
        clr_mon();
        wr(2'd0, 8'd4); ticks(3); wr(2'd0, 8'd4); ticks(3); idle(3);
        chk("R10", "u0 no pulse after kick", hk[0], 0);
        ticks(1); idle(20);
        chk("R10", "u0 pulse after full reload", hk[0], PLEN);

        // R9: narrow build ignores high byte and seconds bit
        cur_req = "R9";
        wr(2'd2, 8'h03); wr(2'd1, 8'h01); clr_mon();
        wr(2'd0, 8'd2); ticks(5); idle(3);
        chk("R9", "u1 no pulse before 2 minutes", hk[1], 0);
        ticks(1); idle(20);
        chk("R9", "u1 pulse at 2 minutes", hk[1], PLEN);
        chk("R9", "u0 still counting 258 s", hk[0], 0);
        wr(2'd1, 8'h00); idle(4);

        summary();
        $finish;
    end

endmodule